// File: doc/BRIEF.md
# Logic Analyzer Waveform Raster Generator

This block turns a captured logic-analyzer record into a monitor picture. It generates 1024 x 768 raster timing from a 65 MHz pixel clock. Two identical phase state machines produce the timing. One steps every clock and paces the columns of a line. The other steps once per finished line and paces the rows of a frame. For every visible column the block computes a sample address, reads the capture memory, and draws the logic levels of the stored samples as traces.

A 2-bit zoom code stretches each sample over 1, 2, 4 or 8 columns. A 2-bit offset code selects which 1024-sample page of the record is shown. A mode input chooses between two layouts:
- **Single-channel:** one full-height trace of channel 0.
- **Four-channel:** four stacked bands, one channel per band.

Green and blue carry the traces, and red carries band divider marks. The memory read costs one clock. The pixel pipeline therefore delays both sync signals so they stay aligned with the colours.

Each timing state machine has four states: `PH_ACTIVE`, `PH_FRONT`, `PH_SYNC` and `PH_BACK`. The transitions are:
- `PH_ACTIVE`→`PH_FRONT`, `PH_FRONT`→`PH_SYNC`, `PH_SYNC`→`PH_BACK` and `PH_BACK`→`PH_ACTIVE`, each taken on the step in which the phase's length count is reached.
- The horizontal machine steps every clock.
- The vertical machine steps only on the horizontal `PH_BACK`→`PH_ACTIVE` transition (line end).
- Both machines are held in `PH_ACTIVE` with a zero count by reset.

Top module: `wave_raster_gen`

## Requirements
- R1: While `rst` is high and directly after its release, `hsync_n` and `vsync_n` are 1 and `red`, `green`, `blue` are 0.
- R2: A line lasts H_ACT+H_FP+H_SW+H_BP clocks. `hsync_n` is low (active low) for exactly H_SW clocks, starting H_ACT+H_FP clocks after the line's first visible column.
- R3: The line counter advances once per completed line. A frame has V_ACT+V_FP+V_SW+V_BP lines. `vsync_n` is low for V_SW whole lines starting at line V_ACT+V_FP, and it changes only outside the horizontal sync pulse.
- R4: All colour outputs are 0 outside the visible column range 0..H_ACT-1 and row range 0..V_ACT-1.
- R5: In a visible column c, `rd_addr` = offset×H_ACT + (c >> zoom), with zoom and offset as unsigned 2-bit codes.
- R6: `rd_data` is taken one clock after its address is presented. The colours and both syncs for raster position p appear two clocks after the timing counters reach p.
- R7: With `mode_quad`=1, row y belongs to band b = y / (V_ACT/4) and shows channel b (`rd_data` bit b). A level 1 is drawn on band row (V_ACT/4)/4, and a level 0 on band row V_ACT/4-1-(V_ACT/4)/4.
- R8: In a column c>0 whose channel bit differs from that of column c-1, a vertical segment covers every band row from the level-1 row to the level-0 row inclusive. Column 0 never draws a segment.
- R9: In four-channel mode, channels 0 and 2 are drawn on `green` only, and channels 1 and 3 on `blue` only. `green` and `blue` are never high together.
- R10: In four-channel mode, `red` is high on the last row of each band across all visible columns, and 0 elsewhere.
- R11: With `mode_quad`=0, only channel 0 is drawn, on `green`, with level 1 on row V_ACT/4 and level 0 on row V_ACT-1-V_ACT/4. Bits 3..1 of `rd_data` are ignored, and `red` and `blue` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_quad | input | 1 | 1 = four-channel bands, 0 = single channel |
| zoom | input | 2 | Columns per sample = 2^zoom |
| offset | input | 2 | Selects the displayed page of H_ACT samples |
| rd_addr | output | ADDR_W | Capture memory read address |
| rd_data | input | 4 | Capture memory read data, one bit per channel, one clock after `rd_addr` |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 1 | Band divider overlay |
| green | output | 1 | Trace colour for channel 0, 2 and single mode |
| blue | output | 1 | Trace colour for channels 1 and 3 |

## Verification
`rd_addr` is due in the same cycle as the raster position that produces it. Colours and syncs are due two clocks later: one clock for the memory read and one for the output register. The bench therefore keeps its own raster position counted from reset release. Each cycle it checks `rd_addr` against the current position, and the pixel and sync outputs against the position two cycles earlier. Mode, zoom and offset change only while the counters are deep in vertical blanking, so the two-cycle lag never mixes two configurations inside a visible pixel.

// File: rtl/vx_pkg.sv
package vx_pkg;
    localparam int NCH = 4;

    typedef enum logic [1:0] {
        PH_ACTIVE,
        PH_FRONT,
        PH_SYNC,
        PH_BACK
    } phase_t;

    function automatic int phase_cw(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return (m < 2) ? 1 : $clog2(m);
    endfunction
endpackage

// File: rtl/sync_phase_fsm.sv
module sync_phase_fsm
    import vx_pkg::*;
#(
    parameter int ACT = 1024,
    parameter int FP  = 24,
    parameter int SW  = 136,
    parameter int BP  = 160,
    localparam int CW = phase_cw(ACT, FP, SW, BP)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] pos,
    output logic          active,
    output logic          sync_n,
    output logic          wrap
);
    phase_t        state_q, state_n;
    logic [CW-1:0] cnt_q, len_m1;

    // next phase and length of the current phase
    always_comb begin
        unique case (state_q)
            PH_ACTIVE: begin state_n = PH_FRONT;  len_m1 = CW'(ACT - 1); end
            PH_FRONT:  begin state_n = PH_SYNC;   len_m1 = CW'(FP - 1);  end
            PH_SYNC:   begin state_n = PH_BACK;   len_m1 = CW'(SW - 1);  end
            PH_BACK:   begin state_n = PH_ACTIVE; len_m1 = CW'(BP - 1);  end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_ACTIVE;
            cnt_q   <= '0;
        end else if (step) begin
            if (cnt_q == len_m1) begin
                state_q <= state_n;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pos    = cnt_q;
        active = (state_q == PH_ACTIVE);
        sync_n = (state_q != PH_SYNC);
        wrap   = step && (state_q == PH_BACK) && (cnt_q == len_m1);
    end
endmodule

// File: rtl/sample_addr_map.sv
module sample_addr_map #(
    parameter int H_ACT  = 1024,
    parameter int HCW    = 10,
    parameter int ADDR_W = 12
) (
    input  logic [HCW-1:0]    col,
    input  logic [1:0]        zoom,
    input  logic [1:0]        offset,
    output logic [ADDR_W-1:0] addr
);
    logic [HCW-1:0]    col_sh;
    logic [ADDR_W-1:0] page_base;

    always_comb begin
        col_sh    = col >> zoom;
        page_base = ADDR_W'(offset) * ADDR_W'(H_ACT);
        addr      = page_base + ADDR_W'(col_sh);
    end
endmodule

// File: rtl/trace_render.sv
module trace_render
    import vx_pkg::*;
#(
    parameter int V_ACT = 768,
    parameter int HCW   = 10,
    parameter int VCW   = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [HCW-1:0] col,
    input  logic [VCW-1:0] row,
    input  logic           act,
    input  logic           hs_in_n,
    input  logic           vs_in_n,
    input  logic           quad,
    input  logic [NCH-1:0] rd_data,
    output logic           quad_s1,
    output logic           hsync_n,
    output logic           vsync_n,
    output logic           red,
    output logic           green,
    output logic           blue
);
    localparam int BH = V_ACT / 4;
    localparam logic [VCW-1:0] HI_Q = VCW'(BH / 4);
    localparam logic [VCW-1:0] LO_Q = VCW'(BH - 1 - BH / 4);
    localparam logic [VCW-1:0] HI_S = VCW'(V_ACT / 4);
    localparam logic [VCW-1:0] LO_S = VCW'(V_ACT - 1 - V_ACT / 4);
    localparam logic [VCW-1:0] LAST = VCW'(BH - 1);

    logic [HCW-1:0] s1_col;
    logic [VCW-1:0] s1_row;
    logic           s1_act, s1_hs, s1_vs, s1_quad;
    logic [NCH-1:0] prev_q;

    logic [1:0]     band, ch;
    logic [VCW-1:0] brow, hi, lo;
    logic           cur, prv, seg, on, r_n, g_n, b_n;

    // stage 1: align raster with the memory read latency
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_col  <= '0;
            s1_row  <= '0;
            s1_act  <= 1'b0;
            s1_hs   <= 1'b1;
            s1_vs   <= 1'b1;
            s1_quad <= 1'b0;
            prev_q  <= '0;
        end else begin
            s1_col  <= col;
            s1_row  <= row;
            s1_act  <= act;
            s1_hs   <= hs_in_n;
            s1_vs   <= vs_in_n;
            s1_quad <= quad;
            prev_q  <= rd_data;
        end
    end

    always_comb begin
        band = 2'd0;
        brow = s1_row;
        if (s1_row >= VCW'(3 * BH)) begin
            band = 2'd3; brow = s1_row - VCW'(3 * BH);
        end else if (s1_row >= VCW'(2 * BH)) begin
            band = 2'd2; brow = s1_row - VCW'(2 * BH);
        end else if (s1_row >= VCW'(BH)) begin
            band = 2'd1; brow = s1_row - VCW'(BH);
        end
        if (s1_quad) begin
            ch = band; hi = HI_Q; lo = LO_Q;
        end else begin
            ch = 2'd0; hi = HI_S; lo = LO_S; brow = s1_row;
        end
        cur = rd_data[ch];
        prv = prev_q[ch];
        seg = (s1_col != '0) && (cur != prv) && (brow >= hi) && (brow <= lo);
        on  = s1_act && ((cur && brow == hi) || (!cur && brow == lo) || seg);
        g_n = on && (!s1_quad || !ch[0]);
        b_n = on && s1_quad && ch[0];
        r_n = s1_act && s1_quad && (brow == LAST);
    end

    // stage 2: output register
    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            red     <= 1'b0;
            green   <= 1'b0;
            blue    <= 1'b0;
        end else begin
            hsync_n <= s1_hs;
            vsync_n <= s1_vs;
            red     <= r_n;
            green   <= g_n;
            blue    <= b_n;
        end
    end

    assign quad_s1 = s1_quad;
endmodule

// File: rtl/wave_raster_gen.sv
module wave_raster_gen
    import vx_pkg::*;
#(
    parameter int H_ACT = 1024,
    parameter int H_FP  = 24,
    parameter int H_SW  = 136,
    parameter int H_BP  = 160,
    parameter int V_ACT = 768,
    parameter int V_FP  = 3,
    parameter int V_SW  = 6,
    parameter int V_BP  = 29,
    localparam int HCW    = phase_cw(H_ACT, H_FP, H_SW, H_BP),
    localparam int VCW    = phase_cw(V_ACT, V_FP, V_SW, V_BP),
    localparam int ADDR_W = $clog2(4 * H_ACT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_quad,
    input  logic [1:0]        zoom,
    input  logic [1:0]        offset,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [NCH-1:0]    rd_data,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              red,
    output logic              green,
    output logic              blue
);
    logic [HCW-1:0] hpos;
    logic [VCW-1:0] vpos;
    logic h_act, h_sn, h_wrap, v_act, v_sn, v_wrap;
    logic quad_s1;

    sync_phase_fsm #(.ACT(H_ACT), .FP(H_FP), .SW(H_SW), .BP(H_BP)) u_hsync (
        .clk(clk), .rst(rst), .step(1'b1),
        .pos(hpos), .active(h_act), .sync_n(h_sn), .wrap(h_wrap)
    );

    sync_phase_fsm #(.ACT(V_ACT), .FP(V_FP), .SW(V_SW), .BP(V_BP)) u_vsync (
        .clk(clk), .rst(rst), .step(h_wrap),
        .pos(vpos), .active(v_act), .sync_n(v_sn), .wrap(v_wrap)
    );

    sample_addr_map #(.H_ACT(H_ACT), .HCW(HCW), .ADDR_W(ADDR_W)) u_addr (
        .col(hpos), .zoom(zoom), .offset(offset), .addr(rd_addr)
    );

    trace_render #(.V_ACT(V_ACT), .HCW(HCW), .VCW(VCW)) u_render (
        .clk(clk), .rst(rst),
        .col(hpos), .row(vpos), .act(h_act && v_act),
        .hs_in_n(h_sn), .vs_in_n(v_sn), .quad(mode_quad),
        .rd_data(rd_data), .quad_s1(quad_s1),
        .hsync_n(hsync_n), .vsync_n(vsync_n),
        .red(red), .green(green), .blue(blue)
    );

    logic unused_wrap;
    assign unused_wrap = v_wrap;
endmodule

// File: rtl/wave_raster_chk.sv
module wave_raster_chk (
    input logic clk,
    input logic rst,
    input logic hsync_n,
    input logic vsync_n,
    input logic red,
    input logic green,
    input logic blue,
    input logic quad_s1
);
    p_blank_hsync_r4: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |-> !(red || green || blue));

    p_blank_vsync_r4: assert property (@(posedge clk) disable iff (rst)
        !vsync_n |-> !(red || green || blue));

    p_colour_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(green && blue));

    p_single_plain_r11: assert property (@(posedge clk) disable iff (rst)
        !quad_s1 |=> !(red || blue));

    p_vedge_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(vsync_n) |-> hsync_n);

    p_hpulse_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |=> !hsync_n);
endmodule

bind wave_raster_gen wave_raster_chk u_chk (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue), .quad_s1(quad_s1)
);

// File: tb/sim_wave_raster_gen.sv
`timescale 1ns/1ps
module sim_wave_raster_gen;
    localparam int HA = 32, HF = 2, HS = 4, HB = 2;
    localparam int VA = 16, VF = 1, VS = 2, VB = 1;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int FRAME = HT * VT;
    localparam int CP = (VA + VF) * HT;
    localparam int BH = VA / 4;
    localparam int AW = $clog2(4 * HA);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_quad = 1'b0;
    logic [1:0] zoom = 2'd0, offset = 2'd0;
    logic [AW-1:0] rd_addr;
    logic [3:0] rd_data = 4'd0;
    logic hsync_n, vsync_n, red, green, blue;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wave_raster_gen #(.H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
                      .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB)) u0 (
        .clk(clk), .rst(rst), .mode_quad(mode_quad), .zoom(zoom),
        .offset(offset), .rd_addr(rd_addr), .rd_data(rd_data),
        .hsync_n(hsync_n), .vsync_n(vsync_n),
        .red(red), .green(green), .blue(blue)
    );

    function automatic logic [3:0] pat(int a);
        return 4'((a ^ (a >> 3) ^ (a >> 5)) & 15);
    endfunction

    // memory model, one clock of read latency
    always @(posedge clk) rd_data <= pat(int'(rd_addr));

    function automatic logic [2:0] pix(int h, int v, bit q, int z, int off);
        logic [3:0] s, pv;
        int ch, r, hi, lo;
        bit lvl, on, rr, gg, bb;
        if (h >= HA || v >= VA) return 3'b000;
        s  = pat(off * HA + (h >> z));
        pv = (h > 0) ? pat(off * HA + ((h - 1) >> z)) : s;
        if (q) begin ch = v / BH; r = v % BH; hi = BH / 4; lo = BH - 1 - BH / 4; end
        else   begin ch = 0; r = v; hi = VA / 4; lo = VA - 1 - VA / 4; end
        lvl = s[ch];
        on  = (lvl && r == hi) || (!lvl && r == lo) ||
              (h > 0 && s[ch] != pv[ch] && r >= hi && r <= lo);
        rr = q && (r == BH - 1);
        gg = on && (!q || (ch % 2 == 0));
        bb = on && q && (ch % 2 == 1);
        return {rr, gg, bb};
    endfunction

    task automatic check_cycle(int n);
        int p, h, v, hn, vn, ea;
        bit ehs, evs;
        logic [2:0] ec;
        string tag;
        // sync and colour outputs: position n-2 (R6)
        if (n < 2) begin
            ehs = 1'b1; evs = 1'b1; ec = 3'b000; h = HA; v = VA;
        end else begin
            p = (n - 2) % FRAME; h = p % HT; v = p / HT;
            ehs = !(h >= HA + HF && h < HA + HF + HS);
            evs = !(v >= VA + VF && v < VA + VF + VS);
            ec  = pix(h, v, mode_quad, int'(zoom), int'(offset));
        end
        checks++;
        if (hsync_n !== ehs || vsync_n !== evs) begin
            fails++;
            $display("FAIL R2/R3 R6 sync n=%0d got hs=%b vs=%b exp hs=%b vs=%b",
                     n, hsync_n, vsync_n, ehs, evs);
        end
        checks++;
        if ({red, green, blue} !== ec) begin
            fails++;
            if (h >= HA || v >= VA)  tag = "R4";
            else if (!mode_quad)     tag = "R11";
            else if (red !== ec[2])  tag = "R10";
            else                     tag = "R7 R8 R9";
            $display("FAIL %s pixel h=%0d v=%0d q=%0b z=%0d o=%0d got rgb=%b exp rgb=%b",
                     tag, h, v, mode_quad, zoom, offset, {red, green, blue}, ec);
        end
        // read address: current position (R5)
        hn = n % HT; vn = (n / HT) % VT;
        if (hn < HA && vn < VA) begin
            ea = int'(offset) * HA + (hn >> int'(zoom));
            checks++;
            if (int'(rd_addr) != ea) begin
                fails++;
                $display("FAIL R5 rd_addr h=%0d got %0d exp %0d", hn, rd_addr, ea);
            end
        end
    endtask

    initial begin
        int n, cfg;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (hsync_n !== 1'b1 || vsync_n !== 1'b1 || {red, green, blue} !== 3'b000) begin
            fails++;
            $display("FAIL R1 reset got hs=%b vs=%b rgb=%b exp 1 1 000",
                     hsync_n, vsync_n, {red, green, blue});
        end
        rst = 1'b0;
        n = 0; cfg = 0;
        {mode_quad, zoom, offset} = 5'd0;
        check_cycle(n);
        while (cfg < 32) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            check_cycle(n);
            if (n % FRAME == CP) begin
                cfg++;
                {mode_quad, zoom, offset} = 5'(cfg);
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule